// File: doc/BRIEF.md
# Dual-Subnet Adaptive Mesh Router

This block is the switching core of one node in a two-dimensional mesh. Each node carries two independent sub-networks: an eastbound one and a westbound one, each with its own horizontal port and its own pair of vertical ports. A packet injected by the local node enters the eastbound subnet when its destination column is at or to the east of the node, and the westbound subnet otherwise. From then on, the packet stays in that subnet until it is ejected at its destination. Two separate subnets mean that no turn can close a cycle, so the network is free of deadlock.

Packets travel by wormhole switching as 64-bit flits. Each link has a valid/ready handshake and a last-flit marker. The router reads the destination from the header flit and chooses a minimal output. The horizontal output is preferred. When that output's downstream buffer is nearly full and a vertical move is also minimal, the router takes the vertical output instead. A header that wins an output keeps it until the flit flagged as last has gone through. When several headers want the same free output in the same cycle, a round-robin arbiter picks one. Flits pass straight through the switch without being buffered. A header is forwarded one cycle after its grant.

Top module: `dsr_router`

## Requirements
- R1: While reset is held, no output presents a valid flit and no input is ready, even when an input offers a flit. After reset, every output is free.
- R2: The header flit holds the destination column in bits 3:0 and the destination row in bits 7:4. A packet injected on the local port (index 0) enters the eastbound subnet when the destination column is greater than or equal to the node column, and the westbound subnet when it is smaller. A packet arriving on the west, east-north or east-south input (indices 4, 2, 3) belongs to the eastbound subnet. A packet arriving on the east, west-north or west-south input (indices 1, 5, 6) belongs to the westbound subnet.
- R3: When the column offset is nonzero and the preferred output is not congested, the header goes to its subnet's horizontal output: east (index 1) for the eastbound subnet, west (index 4) for the westbound subnet.
- R4: When the column offset is zero and the row offset is nonzero, the header goes to its subnet's vertical output. North (greater row) is index 2 in the eastbound subnet and index 5 in the westbound subnet. South is index 3 and index 6 respectively. A local injection in the node's own column therefore uses the eastbound vertical ports.
- R5: A header whose destination equals the node's coordinates leaves on the local output (index 0).
- R6: When both offsets are nonzero, the horizontal output reports fewer than CONG_LIMIT (2) free downstream slots, and the vertical output reports at least CONG_LIMIT free slots, the header takes the vertical output.
- R7: When there is no minimal alternative (row offset zero), or the alternative is also congested, the header keeps the horizontal output whatever its congestion.
- R8: Once granted, an output carries only the flits of the owning packet, in order. It is released only in the cycle in which a flit marked last is accepted. Other headers wanting that output wait.
- R9: Several headers that want the same free output in one cycle are served in round-robin order. The search starts at the port index after the last winner, wrapping from 6 to 0, and starts at 0 after reset.
- R10: While an output's ready is low, the flit on that output stays valid and unchanged. No flit is lost or duplicated.
- R11: The output is chosen once, at grant time. A later change in congestion does not move the body flits of that packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 7 | Per input port: a flit is offered |
| in_data | input | 7x64 | Per input port: flit payload |
| in_last | input | 7 | Per input port: the offered flit ends its packet |
| in_ready | output | 7 | Per input port: the offered flit is accepted this cycle |
| out_valid | output | 7 | Per output port: a flit is offered downstream |
| out_data | output | 7x64 | Per output port: flit payload |
| out_last | output | 7 | Per output port: the flit ends its packet |
| out_ready | input | 7 | Per output port: downstream accepts the flit |
| out_free | input | 7x4 | Per output port: free slots in the downstream buffer |

## Verification
The assertions assume that every upstream sender obeys the handshake. This means it holds a flit, and its last flag, unchanged while it is valid and not yet accepted. They also assume that each packet is a header followed by flits ending in one marked last, and that a packet never needs a non-minimal turn. The bench drives every input through one task that keeps a flit in place until it sees the ready signal, and only ever sends destinations that lie on a minimal path for the input's subnet. Congestion levels are changed only between the clock edges, and the scoreboard predicts which output each packet uses from those levels.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int NUM_PORTS = 7;
    localparam int PORT_W    = 3;

    // Port indices; the arbiter's round-robin order follows these values.
    localparam int P_LOCAL = 0;
    localparam int P_EAST  = 1;
    localparam int P_EN    = 2;
    localparam int P_ES    = 3;
    localparam int P_WEST  = 4;
    localparam int P_WN    = 5;
    localparam int P_WS    = 6;

    typedef struct packed {
        logic [NUM_PORTS-1:0]             busy;
        logic [NUM_PORTS-1:0][PORT_W-1:0] owner;
        logic [NUM_PORTS-1:0][PORT_W-1:0] rr_ptr;
        logic [NUM_PORTS-1:0]             held;
        logic [NUM_PORTS-1:0][PORT_W-1:0] route;
    } sw_state_t;

endpackage

// File: rtl/dsr_route_sel.sv
module dsr_route_sel import dsr_pkg::*; #(
    parameter int COORD_W    = 4,
    parameter int FREE_W     = 4,
    parameter int MY_X       = 2,
    parameter int MY_Y       = 2,
    parameter int CONG_LIMIT = 2,
    parameter int IN_PORT    = 0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               hdr_valid,
    input  logic [COORD_W-1:0]                 dest_x,
    input  logic [COORD_W-1:0]                 dest_y,
    input  logic [NUM_PORTS-1:0][FREE_W-1:0]   out_free,
    output logic [PORT_W-1:0]                  sel
);
    localparam logic [COORD_W-1:0] ME_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] ME_Y = COORD_W'(MY_Y);
    localparam logic [FREE_W-1:0]  LIMIT = FREE_W'(CONG_LIMIT);
    localparam bit IS_LOCAL   = (IN_PORT == P_LOCAL);
    localparam bit FROM_EASTB = (IN_PORT == P_WEST) || (IN_PORT == P_EN) || (IN_PORT == P_ES);

    logic signed [COORD_W:0] dx;
    logic signed [COORD_W:0] dy;
    logic                    eastb;
    logic [PORT_W-1:0]       x_port;
    logic [PORT_W-1:0]       y_port;
    logic                    x_cong;
    logic                    y_cong;

    assign dx = $signed({1'b0, dest_x}) - $signed({1'b0, ME_X});
    assign dy = $signed({1'b0, dest_y}) - $signed({1'b0, ME_Y});

    always_comb begin
        if (IS_LOCAL) eastb = (dx >= 0);
        else          eastb = FROM_EASTB;
        x_port = eastb ? PORT_W'(P_EAST) : PORT_W'(P_WEST);
        if (dy > 0) y_port = eastb ? PORT_W'(P_EN) : PORT_W'(P_WN);
        else        y_port = eastb ? PORT_W'(P_ES) : PORT_W'(P_WS);
        x_cong = out_free[x_port] < LIMIT;
        y_cong = out_free[y_port] < LIMIT;
        if (dx == 0 && dy == 0)  sel = PORT_W'(P_LOCAL);
        else if (dx == 0)        sel = y_port;
        else if (dy == 0)        sel = x_port;
        else if (x_cong && !y_cong) sel = y_port;
        else                     sel = x_port;
    end

    // Subnet separation: a header never leaves through the other subnet.
    assert_subnet_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && eastb) |-> (sel != PORT_W'(P_WEST) && sel != PORT_W'(P_WN) && sel != PORT_W'(P_WS)));
    assert_west_subnet_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !eastb) |-> (sel != PORT_W'(P_EAST) && sel != PORT_W'(P_EN) && sel != PORT_W'(P_ES)));

endmodule

// File: rtl/dsr_rr_arb.sv
module dsr_rr_arb #(
    parameter int N = 7,
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [W-1:0] ptr,
    output logic [W-1:0] gnt_idx,
    output logic         any
);
    always_comb begin
        gnt_idx = '0;
        any     = 1'b0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = (int'(ptr) + k) % N;
            if (!any && req[c]) begin
                any     = 1'b1;
                gnt_idx = W'(c);
            end
        end
    end

    assert_grant_requested_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[gnt_idx]);
    assert_grant_when_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> any);

endmodule

// File: rtl/dsr_router.sv
module dsr_router import dsr_pkg::*; #(
    parameter int FLIT_W     = 64,
    parameter int COORD_W    = 4,
    parameter int FREE_W     = 4,
    parameter int MY_X       = 2,
    parameter int MY_Y       = 2,
    parameter int CONG_LIMIT = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_PORTS-1:0]                 in_valid,
    input  logic [NUM_PORTS-1:0][FLIT_W-1:0]     in_data,
    input  logic [NUM_PORTS-1:0]                 in_last,
    output logic [NUM_PORTS-1:0]                 in_ready,
    output logic [NUM_PORTS-1:0]                 out_valid,
    output logic [NUM_PORTS-1:0][FLIT_W-1:0]     out_data,
    output logic [NUM_PORTS-1:0]                 out_last,
    input  logic [NUM_PORTS-1:0]                 out_ready,
    input  logic [NUM_PORTS-1:0][FREE_W-1:0]     out_free
);
    sw_state_t s_q, s_d;

    logic [NUM_PORTS-1:0][PORT_W-1:0]    sel;
    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] req;
    logic [NUM_PORTS-1:0][PORT_W-1:0]    gidx;
    logic [NUM_PORTS-1:0]                gany;
    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] own_vec;

    // Route choice per input, recomputed every cycle until the header is granted.
    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_sel
        dsr_route_sel #(
            .COORD_W(COORD_W), .FREE_W(FREE_W), .MY_X(MY_X), .MY_Y(MY_Y),
            .CONG_LIMIT(CONG_LIMIT), .IN_PORT(gi)
        ) u_sel (
            .clk(clk),
            .rst_n(rst_n),
            .hdr_valid(in_valid[gi] && !s_q.held[gi]),
            .dest_x(in_data[gi][COORD_W-1:0]),
            .dest_y(in_data[gi][2*COORD_W-1:COORD_W]),
            .out_free(out_free),
            .sel(sel[gi])
        );
    end

    always_comb begin
        for (int o = 0; o < NUM_PORTS; o++) begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                req[o][i] = in_valid[i] && !s_q.held[i] && (sel[i] == PORT_W'(o));
            end
        end
    end

    // One arbiter per output.
    for (genvar go = 0; go < NUM_PORTS; go++) begin : g_arb
        dsr_rr_arb #(.N(NUM_PORTS), .W(PORT_W)) u_arb (
            .clk(clk),
            .rst_n(rst_n),
            .req(req[go]),
            .ptr(s_q.rr_ptr[go]),
            .gnt_idx(gidx[go]),
            .any(gany[go])
        );
    end

    // Crossbar datapath.
    always_comb begin
        for (int o = 0; o < NUM_PORTS; o++) begin
            out_valid[o] = s_q.busy[o] && in_valid[s_q.owner[o]];
            out_data[o]  = s_q.busy[o] ? in_data[s_q.owner[o]] : '0;
            out_last[o]  = s_q.busy[o] && in_last[s_q.owner[o]];
        end
        for (int i = 0; i < NUM_PORTS; i++) begin
            in_ready[i] = s_q.held[i] && s_q.busy[s_q.route[i]] && out_ready[s_q.route[i]];
        end
    end

    // Next-state: allocation and release of outputs.
    always_comb begin
        s_d = s_q;
        for (int o = 0; o < NUM_PORTS; o++) begin
            if (s_q.busy[o]) begin
                if (out_valid[o] && out_ready[o] && out_last[o]) begin
                    s_d.busy[o]              = 1'b0;
                    s_d.held[s_q.owner[o]]   = 1'b0;
                end
            end else if (gany[o]) begin
                s_d.busy[o]          = 1'b1;
                s_d.owner[o]         = gidx[o];
                s_d.held[gidx[o]]    = 1'b1;
                s_d.route[gidx[o]]   = PORT_W'(o);
                s_d.rr_ptr[o]        = (gidx[o] == PORT_W'(NUM_PORTS-1)) ? '0 : gidx[o] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            for (int o = 0; o < NUM_PORTS; o++) begin
                own_vec[i][o] = s_q.busy[o] && (s_q.owner[o] == PORT_W'(i));
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (s_q.busy == '0 && out_valid == '0 && in_ready == '0));

    for (genvar ga = 0; ga < NUM_PORTS; ga++) begin : g_chk
        assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.busy[ga] && !(out_valid[ga] && out_ready[ga] && out_last[ga]))
            |=> (s_q.busy[ga] && $stable(s_q.owner[ga])));
        assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(own_vec[ga]));
        assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[ga] && !out_ready[ga])
            |=> (out_valid[ga] && $stable(out_data[ga]) && $stable(out_last[ga])));
        assert_route_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.held[ga] && $past(s_q.held[ga])) |-> $stable(s_q.route[ga]));
    end

endmodule

// File: tb/sim_dsr_router.sv
module sim_dsr_router;
    import dsr_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_PORTS-1:0]            in_valid = '0;
    logic [NUM_PORTS-1:0][63:0]      in_data = '0;
    logic [NUM_PORTS-1:0]            in_last = '0;
    logic [NUM_PORTS-1:0]            in_ready;
    logic [NUM_PORTS-1:0]            out_valid;
    logic [NUM_PORTS-1:0][63:0]      out_data;
    logic [NUM_PORTS-1:0]            out_last;
    logic [NUM_PORTS-1:0]            out_ready = '1;
    logic [NUM_PORTS-1:0][3:0]       out_free = {NUM_PORTS{4'd8}};

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] d;
        logic        l;
        string       req;
    } exp_t;
    exp_t eq [NUM_PORTS][$];

    always #5 clk = ~clk;

    dsr_router u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .out_free(out_free)
    );

    function automatic logic [63:0] mk(logic [7:0] tag, int i, logic [3:0] tx, logic [3:0] ty);
        return {tag, 8'(i), 40'hC0FFEE1234, ty, tx};
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] got, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic expect_pkt(int o, logic [7:0] tag, logic [3:0] tx, logic [3:0] ty, int nb, string req);
        for (int i = 0; i <= nb; i++) begin
            exp_t e;
            e.d = mk(tag, i, tx, ty);
            e.l = (i == nb);
            e.req = req;
            eq[o].push_back(e);
        end
    endtask

    // Driver: holds each flit until accepted. Called just after a rising edge.
    task automatic send_pkt(int p, logic [7:0] tag, logic [3:0] tx, logic [3:0] ty, int nb);
        for (int i = 0; i <= nb; i++) begin
            in_valid[p] = 1'b1;
            in_data[p]  = mk(tag, i, tx, ty);
            in_last[p]  = (i == nb);
            do @(negedge clk); while (!in_ready[p]);
            @(posedge clk);
            #1;
        end
        in_valid[p] = 1'b0;
        in_last[p]  = 1'b0;
    endtask

    task automatic drain(string req);
        int w = 0;
        bit busy_q = 1'b1;
        while (busy_q && w < 400) begin
            @(negedge clk);
            w++;
            busy_q = 1'b0;
            for (int o = 0; o < NUM_PORTS; o++) if (eq[o].size() != 0) busy_q = 1'b1;
        end
        for (int o = 0; o < NUM_PORTS; o++)
            check(eq[o].size() == 0, req, $sformatf("flits still owed on port %0d", o),
                  64'(eq[o].size()), 64'd0);
        @(posedge clk);
        #1;
    endtask

    // Monitor: compares every accepted output flit with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int o = 0; o < NUM_PORTS; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    if (eq[o].size() == 0) begin
                        check(1'b0, "R8", $sformatf("unexpected flit on port %0d", o), out_data[o], 64'd0);
                    end else begin
                        exp_t e;
                        e = eq[o].pop_front();
                        check(out_data[o] == e.d && out_last[o] == e.l, e.req,
                              $sformatf("flit on port %0d", o), out_data[o], e.d);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R8 watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: flit offered during reset is neither accepted nor forwarded
        in_valid[P_LOCAL] = 1'b1;
        in_data[P_LOCAL]  = mk(8'h00, 0, 4'd6, 4'd2);
        in_last[P_LOCAL]  = 1'b1;
        repeat (3) @(negedge clk);
        check(in_ready == '0, "R1", "in_ready during reset", 64'(in_ready), 64'd0);
        check(out_valid == '0, "R1", "out_valid during reset", 64'(out_valid), 64'd0);
        in_valid[P_LOCAL] = 1'b0;
        in_last[P_LOCAL]  = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == '0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        @(posedge clk); #1;

        // R9: east-south input and west input both want east-north; index 3 wins
        // first, then the search starts at 4 so the west input beats the repeat.
        expect_pkt(P_EN, 8'h01, 4'd2, 4'd5, 2, "R9");
        expect_pkt(P_EN, 8'h02, 4'd2, 4'd6, 2, "R9");
        expect_pkt(P_EN, 8'h03, 4'd2, 4'd5, 1, "R9");
        fork
            begin
                send_pkt(P_ES, 8'h01, 4'd2, 4'd5, 2);
                send_pkt(P_ES, 8'h03, 4'd2, 4'd5, 1);
            end
            send_pkt(P_WEST, 8'h02, 4'd2, 4'd6, 2);
        join
        drain("R9");

        // R2 and R3: local injection picks the subnet by column, X port preferred
        expect_pkt(P_EAST, 8'h04, 4'd6, 4'd2, 1, "R2");
        send_pkt(P_LOCAL, 8'h04, 4'd6, 4'd2, 1);
        expect_pkt(P_WEST, 8'h05, 4'd0, 4'd2, 1, "R2");
        send_pkt(P_LOCAL, 8'h05, 4'd0, 4'd2, 1);
        expect_pkt(P_EAST, 8'h06, 4'd5, 4'd5, 0, "R3");
        send_pkt(P_LOCAL, 8'h06, 4'd5, 4'd5, 0);
        expect_pkt(P_WEST, 8'h07, 4'd0, 4'd0, 1, "R3");
        send_pkt(P_EAST, 8'h07, 4'd0, 4'd0, 1);
        drain("R3");

        // R4: same column goes vertical within the subnet
        expect_pkt(P_ES, 8'h08, 4'd2, 4'd0, 1, "R4");
        send_pkt(P_LOCAL, 8'h08, 4'd2, 4'd0, 1);
        expect_pkt(P_WN, 8'h09, 4'd2, 4'd4, 1, "R4");
        send_pkt(P_EAST, 8'h09, 4'd2, 4'd4, 1);
        expect_pkt(P_WS, 8'h0A, 4'd2, 4'd1, 0, "R4");
        send_pkt(P_WN, 8'h0A, 4'd2, 4'd1, 0);
        drain("R4");

        // R5: arrival at the node ejects locally
        expect_pkt(P_LOCAL, 8'h0B, 4'd2, 4'd2, 2, "R5");
        send_pkt(P_WEST, 8'h0B, 4'd2, 4'd2, 2);
        expect_pkt(P_LOCAL, 8'h0C, 4'd2, 4'd2, 0, "R5");
        send_pkt(P_WN, 8'h0C, 4'd2, 4'd2, 0);
        drain("R5");

        // R6: congested X port diverts to the free vertical port
        out_free[P_EAST] = 4'd1;
        expect_pkt(P_EN, 8'h0D, 4'd5, 4'd4, 1, "R6");
        send_pkt(P_LOCAL, 8'h0D, 4'd5, 4'd4, 1);
        out_free[P_EAST] = 4'd8;
        out_free[P_WEST] = 4'd0;
        expect_pkt(P_WS, 8'h0E, 4'd0, 4'd0, 1, "R6");
        send_pkt(P_EAST, 8'h0E, 4'd0, 4'd0, 1);
        out_free[P_WEST] = 4'd8;
        drain("R6");

        // R7: no usable alternative keeps the X port
        out_free[P_EAST] = 4'd0;
        out_free[P_EN]   = 4'd1;
        expect_pkt(P_EAST, 8'h0F, 4'd5, 4'd4, 1, "R7");
        send_pkt(P_LOCAL, 8'h0F, 4'd5, 4'd4, 1);
        expect_pkt(P_EAST, 8'h10, 4'd7, 4'd2, 1, "R7");
        send_pkt(P_WEST, 8'h10, 4'd7, 4'd2, 1);
        out_free[P_EAST] = 4'd8;
        out_free[P_EN]   = 4'd8;
        drain("R7");

        // R8, R10, R11: long packet holds east; stall mid-packet; congestion
        // rises after grant; a second header to east waits for the last flit.
        expect_pkt(P_EAST, 8'h20, 4'd6, 4'd3, 5, "R8");
        expect_pkt(P_EAST, 8'h21, 4'd7, 4'd2, 2, "R8");
        fork
            send_pkt(P_LOCAL, 8'h20, 4'd6, 4'd3, 5);
            begin
                repeat (2) @(posedge clk);
                #1;
                send_pkt(P_WEST, 8'h21, 4'd7, 4'd2, 2);
            end
            begin
                repeat (3) @(posedge clk);
                #1;
                out_free[P_EAST]  = 4'd0;
                out_ready[P_EAST] = 1'b0;
                repeat (4) begin
                    @(negedge clk);
                    check(out_valid[P_EAST] && eq[P_EAST].size() != 0 &&
                          out_data[P_EAST] == eq[P_EAST][0].d, "R10", "stalled flit held",
                          out_data[P_EAST], (eq[P_EAST].size() != 0) ? eq[P_EAST][0].d : 64'd0);
                    check(!out_valid[P_EN], "R11", "body diverted to east-north",
                          64'(out_valid[P_EN]), 64'd0);
                end
                @(posedge clk);
                #1;
                out_ready[P_EAST] = 1'b1;
            end
        join
        out_free[P_EAST] = 4'd8;
        drain("R8");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule